// File: doc/BRIEF.md
# Stereo PCM Serial Output Formatter

This block turns a pair of two's-complement audio samples (left and right) into a three-wire serial stream: a bit clock, a frame clock that is high while the left channel is sent, and a data line. A word clock that runs at twice the frame rate is produced alongside them. The bit clock is derived from the system clock by a fixed divider. Each stereo frame lasts either 48 or 64 bit clocks, depending on a mode input.

Inside each half-frame the channel word goes out MSB first and is right-justified: its LSB occupies the last bit slot before the frame clock changes level, and the slots ahead of the MSB carry zeros. The output word is 16, 18 or 20 bits long. The short frame always uses 16 bits. Samples wider than the output word lose their low-order bits. New samples and new mode settings are taken once per frame, at the start of the left half, through a valid/ready handshake. When no sample is offered, the previous pair is sent again.

Top module: `pcm_ser_fmt`

## Requirements
- R1: `bclk` is low out of reset and toggles every HALF_DIV system clock cycles, so one bit-clock period is 2*HALF_DIV cycles.
- R2: With `frame_long`=0 a frame lasts 48 bit clocks; with `frame_long`=1 it lasts 64. `lrck` is high for the first half of the frame (left channel) and low for the second half (right channel).
- R3: In a 64-clock frame, `word_code` 2'b00 gives 16 output bits, 2'b01 gives 18, 2'b10 gives 20 and 2'b11 gives 16. A 48-clock frame always carries 16 bits, whatever `word_code` holds.
- R4: In each half-frame the word goes out MSB first. Its LSB is in the last bit slot before `lrck` changes level, and every earlier slot of that half carries 0.
- R5: The output word is the W most significant bits of the SAMPLE_W-bit sample, where W is the length chosen by R3. The low-order bits are dropped.
- R6: `sdata`, `lrck` and `wclk` change only on the system clock edge on which `bclk` falls.
- R7: `wclk` is high during the first half of every half-frame and low during the second half, so it runs at twice the frame rate.
- R8: `s_ready` is high for exactly one system clock cycle per frame. That cycle ends at the edge on which `bclk` falls into the first left slot. If `s_valid` is high in that cycle, both samples are captured on that edge.
- R9: If no handshake takes place at a frame start, the previously captured samples are sent again.
- R10: While reset is asserted, `bclk`, `lrck`, `wclk`, `sdata` and `s_ready` are all low. After reset is released, `s_ready` first goes high after the (2*HALF_DIV-1)-th rising clock edge.
- R11: `frame_long` and `word_code` are sampled only on the frame-start edge of R8, whether or not `s_valid` is high. A change in the middle of a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_long | input | 1 | 0: 48 bit clocks per frame, 1: 64 |
| word_code | input | 2 | Output word length select (see R3) |
| s_valid | input | 1 | New sample pair offered |
| s_ready | output | 1 | Sample pair taken at this edge when valid |
| s_left | input | SAMPLE_W | Left sample, two's complement |
| s_right | input | SAMPLE_W | Right sample, two's complement |
| bclk | output | 1 | Serial bit clock |
| lrck | output | 1 | Frame clock, high for the left half |
| wclk | output | 1 | Word clock at twice the frame rate |
| sdata | output | 1 | Serial data, changes on the falling edge of bclk |

## Verification
The assertions assume that HALF_DIV is at least 2, so that a falling edge of `bclk` is never followed directly by another tick. On that assumption the single-cycle `s_ready` pulse and the hold windows of the frame clock are well defined. They also assume that inputs change only between clock edges. The stimulus therefore drives all inputs on the falling system clock edge and holds `s_valid` and the sample pair steady until it sees `s_ready`. Mode changes in the middle of a frame are made on purpose, to show that they take effect only at the next frame start.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;

   // word length select codes on the mode input
   typedef enum logic [1:0] {
      WL_16  = 2'b00,
      WL_18  = 2'b01,
      WL_20  = 2'b10,
      WL_16X = 2'b11
   } wlen_e;

   localparam int unsigned MIN_WL = 16;
   localparam int unsigned MAX_WL = 20;
   localparam int unsigned NUM_WL = 3;
   localparam int unsigned WL_W   = 5;

   // index into the truncation table: 0 -> 16, 1 -> 18, 2 -> 20
   function automatic logic [1:0] wl_index(input logic [1:0] code, input logic long_frame);
      logic [1:0] r;
      r = 2'd0;
      if (long_frame) begin
         case (wlen_e'(code))
            WL_18:   r = 2'd1;
            WL_20:   r = 2'd2;
            default: r = 2'd0;
         endcase
      end
      return r;
   endfunction

   function automatic logic [WL_W-1:0] wl_bits(input logic [1:0] idx);
      return WL_W'(MIN_WL) + {2'b00, idx, 1'b0};
   endfunction

endpackage

// File: rtl/pcm_bclk_gen.sv
module pcm_bclk_gen #(
   parameter int unsigned HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic bclk,
   output logic fall_tick
);
   localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

   initial begin
      assert (HALF_DIV >= 2) else $error("pcm_bclk_gen: HALF_DIV must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic             term;

   assign term      = (cnt == CNT_LAST);
   assign fall_tick = term & bclk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         bclk <= 1'b0;
      end else if (term) begin
         cnt  <= '0;
         bclk <= ~bclk;
      end else begin
         cnt  <= cnt + CNT_W'(1);
      end
   end

   // R1
   bclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !term |=> $stable(bclk));
   // R1
   bclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term |=> (bclk != $past(bclk)));

endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq
   import pcm_fmt_pkg::*;
#(
   parameter int unsigned SHORT_FRAME = 48,
   parameter int unsigned LONG_FRAME  = 64
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            fall_tick,
   input  logic                            long_req,
   input  logic [1:0]                      wcode_req,
   output logic                            frame_start,
   output logic                            lrck,
   output logic                            wclk,
   output logic                            nxt_left,
   output logic [$clog2(LONG_FRAME)-1:0]   nxt_pos,
   output logic [$clog2(LONG_FRAME)-1:0]   nxt_half,
   output logic [1:0]                      nxt_wsel
);
   localparam int unsigned SLOT_W = $clog2(LONG_FRAME);
   localparam logic [SLOT_W-1:0] LONG_LAST  = SLOT_W'(LONG_FRAME - 1);
   localparam logic [SLOT_W-1:0] SHORT_LAST = SLOT_W'(SHORT_FRAME - 1);
   localparam logic [SLOT_W-1:0] LONG_HALF  = SLOT_W'(LONG_FRAME / 2);
   localparam logic [SLOT_W-1:0] SHORT_HALF = SLOT_W'(SHORT_FRAME / 2);

   initial begin
      assert (SHORT_FRAME % 2 == 0 && LONG_FRAME % 2 == 0)
         else $error("pcm_frame_seq: frame lengths must be even");
      assert (SHORT_FRAME < LONG_FRAME)
         else $error("pcm_frame_seq: short frame must be shorter than long frame");
      assert (SHORT_FRAME / 2 > MIN_WL && LONG_FRAME / 2 > MAX_WL)
         else $error("pcm_frame_seq: half-frames must exceed the word length");
   end

   logic [SLOT_W-1:0] slot, slot_n, last_slot, half_n, pos_n;
   logic              long_q, long_n, wrap, left_n, wclk_n;
   logic [1:0]        wsel_q, wsel_n;

   // frame length of the frame in progress
   assign last_slot = long_q ? LONG_LAST : SHORT_LAST;
   assign wrap      = (slot >= last_slot);

   // mode is taken only at the frame boundary
   assign long_n = wrap ? long_req : long_q;
   assign wsel_n = wrap ? wl_index(wcode_req, long_req) : wsel_q;

   // look-ahead: the slot about to start at the next falling bit-clock edge
   assign slot_n = wrap ? '0 : slot + SLOT_W'(1);
   assign half_n = long_n ? LONG_HALF : SHORT_HALF;
   assign left_n = (slot_n < half_n);
   assign pos_n  = left_n ? slot_n : slot_n - half_n;
   assign wclk_n = (pos_n < (half_n >> 1));

   assign frame_start = fall_tick & wrap;
   assign nxt_left    = left_n;
   assign nxt_pos     = pos_n;
   assign nxt_half    = half_n;
   assign nxt_wsel    = wsel_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot   <= LONG_LAST;
         long_q <= 1'b0;
         wsel_q <= 2'd0;
         lrck   <= 1'b0;
         wclk   <= 1'b0;
      end else if (fall_tick) begin
         slot   <= slot_n;
         long_q <= long_n;
         wsel_q <= wsel_n;
         lrck   <= left_n;
         wclk   <= wclk_n;
      end
   end

   // R2
   lrck_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lrck) |-> (slot == '0));
   // R6
   lr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_tick |=> ($stable(lrck) && $stable(wclk)));
   // R8
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);
   // R11
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(long_q) && $stable(wsel_q)));

endmodule

// File: rtl/pcm_word_unit.sv
module pcm_word_unit
   import pcm_fmt_pkg::*;
#(
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned SLOT_W   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fall_tick,
   input  logic                frame_start,
   input  logic                s_valid,
   input  logic [SAMPLE_W-1:0] s_left,
   input  logic [SAMPLE_W-1:0] s_right,
   input  logic                nxt_left,
   input  logic [SLOT_W-1:0]   nxt_pos,
   input  logic [SLOT_W-1:0]   nxt_half,
   input  logic [1:0]          nxt_wsel,
   output logic                sdata
);
   localparam int unsigned NUM_CH = 2;

   initial begin
      assert (SAMPLE_W >= MAX_WL) else $error("pcm_word_unit: SAMPLE_W below widest word");
      assert (SLOT_W >= WL_W) else $error("pcm_word_unit: SLOT_W too narrow");
   end

   logic [SAMPLE_W-1:0] chan_in [NUM_CH];
   logic [SAMPLE_W-1:0] hold    [NUM_CH];
   logic [SAMPLE_W-1:0] sel;
   logic [MAX_WL-1:0]   trunc   [NUM_WL];
   logic [MAX_WL-1:0]   word;
   logic [WL_W-1:0]     wbits;
   logic [SLOT_W-1:0]   lead, idx;
   logic                bit_n;

   assign chan_in[0] = s_left;
   assign chan_in[1] = s_right;

   // one capture register per channel
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [SAMPLE_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else if (frame_start && s_valid) q <= chan_in[ch];
      end
      assign hold[ch] = q;
   end

   assign sel = nxt_left ? hold[0] : hold[1];

   // truncated word for each selectable length, top bits kept
   for (genvar g = 0; g < NUM_WL; g++) begin : g_trunc
      localparam int unsigned WLG = MIN_WL + 2 * g;
      assign trunc[g] = MAX_WL'(sel[SAMPLE_W-1 -: WLG]);
   end

   always_comb begin
      case (nxt_wsel)
         2'd1:    word = trunc[1];
         2'd2:    word = trunc[2];
         default: word = trunc[0];
      endcase
   end

   // right justification: leading pad slots, then MSB .. LSB
   assign wbits = wl_bits(nxt_wsel);
   assign lead  = nxt_half - SLOT_W'(wbits);
   assign idx   = nxt_half - SLOT_W'(1) - nxt_pos;
   assign bit_n = (nxt_pos >= lead) ? word[WL_W'(idx)] : 1'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) sdata <= 1'b0;
      else if (fall_tick) sdata <= bit_n;
   end

   // R9
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_start && s_valid) |=> ($stable(hold[0]) && $stable(hold[1])));
   // R6
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_tick |=> $stable(sdata));

endmodule

// File: rtl/pcm_ser_fmt.sv
module pcm_ser_fmt #(
   parameter int unsigned SAMPLE_W    = 24,
   parameter int unsigned HALF_DIV    = 2,
   parameter int unsigned SHORT_FRAME = 48,
   parameter int unsigned LONG_FRAME  = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_long,
   input  logic [1:0]          word_code,
   input  logic                s_valid,
   output logic                s_ready,
   input  logic [SAMPLE_W-1:0] s_left,
   input  logic [SAMPLE_W-1:0] s_right,
   output logic                bclk,
   output logic                lrck,
   output logic                wclk,
   output logic                sdata
);
   localparam int unsigned SLOT_W = $clog2(LONG_FRAME);

   logic              fall_tick, frame_start, nxt_left;
   logic [SLOT_W-1:0] nxt_pos, nxt_half;
   logic [1:0]        nxt_wsel;

   pcm_bclk_gen #(.HALF_DIV(HALF_DIV)) u_bclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk      (bclk),
      .fall_tick (fall_tick)
   );

   pcm_frame_seq #(.SHORT_FRAME(SHORT_FRAME), .LONG_FRAME(LONG_FRAME)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .fall_tick   (fall_tick),
      .long_req    (frame_long),
      .wcode_req   (word_code),
      .frame_start (frame_start),
      .lrck        (lrck),
      .wclk        (wclk),
      .nxt_left    (nxt_left),
      .nxt_pos     (nxt_pos),
      .nxt_half    (nxt_half),
      .nxt_wsel    (nxt_wsel)
   );

   pcm_word_unit #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_word (
      .clk         (clk),
      .rst_n       (rst_n),
      .fall_tick   (fall_tick),
      .frame_start (frame_start),
      .s_valid     (s_valid),
      .s_left      (s_left),
      .s_right     (s_right),
      .nxt_left    (nxt_left),
      .nxt_pos     (nxt_pos),
      .nxt_half    (nxt_half),
      .nxt_wsel    (nxt_wsel),
      .sdata       (sdata)
   );

   assign s_ready = frame_start;

   // R4
   pad_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lrck) |-> !sdata);
   // R8
   ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |=> $fell(bclk));
   // R10
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!bclk && !lrck && !wclk && !sdata));

endmodule

// File: tb/pcm_ser_fmt_test.sv
`timescale 1ns/1ps
module pcm_ser_fmt_test;
   localparam int HD = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_long = 1'b0;
   logic [1:0]  word_code = 2'b00;
   logic        s_valid = 1'b0;
   logic [23:0] s_left = '0;
   logic [23:0] s_right = '0;
   logic        s_ready, bclk, lrck, wclk, sdata;

   pcm_ser_fmt #(.SAMPLE_W(24), .HALF_DIV(HD)) uut (
      .clk(clk), .rst_n(rst_n), .frame_long(frame_long), .word_code(word_code),
      .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
      .bclk(bclk), .lrck(lrck), .wclk(wclk), .sdata(sdata)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   // receiver state
   logic        prev_b = 1'b0, prev_sd = 1'b0, prev_lr = 1'b0, cur_lr = 1'b0;
   logic [63:0] sh = '0, wp = '0;
   int          cnt = 0;
   logic [63:0] snap_bits [2];
   logic [63:0] snap_wp   [2];
   int          snap_cnt  [2];
   int          halves_done = 0;
   int          last_rise = 0, per_seen = 0, per_bad = 0, edge_bad = 0;

   task automatic summary_and_end();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         prev_b = 1'b0; prev_sd = 1'b0; prev_lr = 1'b0; cur_lr = 1'b0;
         sh = '0; wp = '0; cnt = 0;
      end else begin
         if ((sdata !== prev_sd || lrck !== prev_lr) && !(prev_b && !bclk)) edge_bad++;
         if (!prev_b && bclk) begin
            if (per_seen > 0 && (cyc - last_rise) != 2 * HD) per_bad++;
            per_seen++;
            last_rise = cyc;
            if (lrck !== cur_lr) begin
               snap_bits[cur_lr ? 0 : 1] = sh;
               snap_wp[cur_lr ? 0 : 1]   = wp;
               snap_cnt[cur_lr ? 0 : 1]  = cnt;
               halves_done++;
               sh = '0; wp = '0; cnt = 0;
               cur_lr = lrck;
            end
            sh = {sh[62:0], sdata};
            wp = {wp[62:0], wclk};
            cnt++;
         end
         prev_b = bclk; prev_sd = sdata; prev_lr = lrck;
      end
      if (cyc > 150000 && !done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, actual=%0d cycles expected<150000", cyc);
         summary_and_end();
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int exp_w(input logic f64, input logic [1:0] code);
      if (!f64) return 16;
      if (code == 2'b01) return 18;
      if (code == 2'b10) return 20;
      return 16;
   endfunction

   function automatic logic [63:0] exp_word(input logic [23:0] s, input int w);
      return 64'(s >> (24 - w));
   endfunction

   function automatic logic [63:0] exp_wclk(input int half);
      return ((64'd1 << (half / 2)) - 64'd1) << (half / 2);
   endfunction

   task automatic do_frame(input logic f64, input logic [1:0] code, input logic [23:0] l,
                           input logic [23:0] r, input logic v,
                           input logic [23:0] el, input logic [23:0] er);
      int h0, w, half;
      @(negedge clk);
      frame_long = f64; word_code = code; s_left = l; s_right = r; s_valid = v;
      while (!s_ready) @(negedge clk);
      h0 = halves_done;
      @(negedge clk);
      s_valid = 1'b0;
      chk("R8 s_ready lasts one cycle", 64'(s_ready), 64'd0);
      wait (halves_done >= h0 + 3);
      w = exp_w(f64, code);
      half = f64 ? 32 : 24;
      chk("R2 bit clocks per half (left,right)", {32'(snap_cnt[0]), 32'(snap_cnt[1])},
          {32'(half), 32'(half)});
      chk("R3/R4/R5 left word", snap_bits[0], exp_word(el, w));
      chk("R3/R4/R5 right word", snap_bits[1], exp_word(er, w));
      chk("R7 word clock pattern", snap_wp[0] & snap_wp[1], exp_wclk(half));
   endtask

   // {frame_long, word_code, left, right}
   localparam logic [50:0] VEC [8] = '{
      {1'b0, 2'b00, 24'h123456, 24'hFEDCBA},
      {1'b1, 2'b00, 24'h800001, 24'h7FFFFF},
      {1'b1, 2'b01, 24'hABCDEF, 24'h5A5A5A},
      {1'b1, 2'b10, 24'hFFFFFF, 24'h000010},
      {1'b0, 2'b10, 24'h876543, 24'h0F0F0F},
      {1'b1, 2'b11, 24'hC00000, 24'h3FFFFF},
      {1'b1, 2'b10, 24'h800000, 24'h7FFFF0},
      {1'b0, 2'b00, 24'h000000, 24'h00FFFF}
   };

   initial begin
      int k, h1;
      logic [50:0] v;
      // R10 reset state
      repeat (4) @(negedge clk);
      chk("R10 outputs low in reset", {59'd0, bclk, lrck, wclk, sdata, s_ready}, 64'd0);
      rst_n = 1'b1;
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!s_ready && k < 50);
      chk("R10 first s_ready cycle", 64'(k), 64'(2 * HD - 1));

      for (int i = 0; i < 8; i++) begin
         v = VEC[i];
         do_frame(v[50], v[49:48], v[47:24], v[23:0], 1'b1, v[47:24], v[23:0]);
      end

      // R9: no valid, previous pair (last vector) repeated at 18 bits
      do_frame(1'b1, 2'b01, 24'hDEAD00, 24'hBEEF00, 1'b0, 24'h000000, 24'h00FFFF);

      // R11: mode change in mid-frame affects only the following frame
      @(negedge clk);
      frame_long = 1'b1; word_code = 2'b10;
      s_left = 24'h13579B; s_right = 24'h2468AC; s_valid = 1'b1;
      while (!s_ready) @(negedge clk);
      k = halves_done;
      @(negedge clk);
      s_valid = 1'b0;
      wait (halves_done >= k + 1);
      @(negedge clk);
      frame_long = 1'b0; word_code = 2'b00;
      wait (halves_done >= k + 3);
      chk("R11 mid-frame change ignored, counts", {32'(snap_cnt[0]), 32'(snap_cnt[1])},
          {32'd32, 32'd32});
      chk("R11 mid-frame change ignored, left word", snap_bits[0], exp_word(24'h13579B, 20));
      while (!s_ready) @(negedge clk);
      h1 = halves_done;
      wait (halves_done >= h1 + 3);
      chk("R11 new mode at next frame, counts", {32'(snap_cnt[0]), 32'(snap_cnt[1])},
          {32'd24, 32'd24});
      chk("R9 repeated right word after mode change", snap_bits[1], exp_word(24'h2468AC, 16));

      chk("R1 bit clock period errors", 64'(per_bad), 64'd0);
      chk("R1 bit clock rises seen", 64'(per_seen > 100), 64'd1);
      chk("R6 changes away from bclk fall", 64'(edge_bad), 64'd0);

      done = 1'b1;
      summary_and_end();
   end
endmodule